// File: doc/BRIEF.md
# Bidirectional Single-Byte Mailbox Link

This block joins a master processor bus and a slave processor bus through two independent one-byte mailboxes. The downstream mailbox carries bytes from master to slave, and the upstream mailbox carries bytes from slave to master. Each mailbox has two active-low flags. The writing side sees a "room" flag, which is low when it may write. The reading side sees an "available" flag, which is low when a byte is waiting for it. Only one byte is in flight per direction. A byte must be taken before the next one can be loaded.

Both sides share one clock and access their mailbox with single-cycle strobes. They poll the flags, or react to them, before each access. The hardware does not rely on software to keep to the protocol:
- A write to a full mailbox is refused, and a sticky overrun flag is raised on the writer's side.
- A read of an empty mailbox returns the byte last stored, and a sticky underrun flag is raised on the reader's side.
- One clear input drops all four sticky flags.

Top module: `mbox_link_top`

## Requirements
- R1: After reset both mailboxes are empty and hold 0x00. Both room flags (`m_dn_room_n`, `s_up_room_n`) are low, both available flags (`s_dn_avail_n`, `m_up_avail_n`) are high, and all four sticky flags are low.
- R2: A master write strobe while the downstream mailbox is empty stores `m_wr_data`. On the next clock edge `m_dn_room_n` goes high and `s_dn_avail_n` goes low.
- R3: A slave read strobe while the downstream mailbox is full empties it. On the next clock edge `s_dn_avail_n` goes high and `m_dn_room_n` goes low.
- R4: The upstream mailbox mirrors R2 and R3. A slave write into an empty upstream mailbox drives `s_up_room_n` high and `m_up_avail_n` low on the next edge. A master read of a full upstream mailbox drives `m_up_avail_n` high and `s_up_room_n` low on the next edge.
- R5: Each read-data port shows the stored byte of its mailbox combinationally while that side's read strobe is high. It shows 0x00 while the strobe is low.
- R6: A write strobe to a full mailbox is refused and leaves the stored byte unchanged. From the next edge it sets the writer's sticky overrun flag: `m_overrun` for downstream, `s_overrun` for upstream.
- R7: A read strobe to an empty mailbox returns the byte last stored and leaves both flags unchanged. From the next edge it sets the reader's sticky underrun flag: `s_underrun` for downstream, `m_underrun` for upstream.
- R8: If a read and a write reach a full mailbox in the same cycle, the read takes the stored byte and the write is refused. The mailbox is empty after the edge, and the writer's overrun flag is set.
- R9: If a read and a write reach an empty mailbox in the same cycle, the write is stored, the mailbox is full after the edge, and the reader's underrun flag is set.
- R10: A sticky flag stays high until `err_clr` is sampled high. A new error event in the same cycle as `err_clr` keeps its flag high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock for both sides |
| rst_n | input | 1 | Synchronous active-low reset |
| m_wr_stb | input | 1 | Master write strobe into the downstream mailbox |
| m_wr_data | input | 8 | Master write byte |
| m_rd_stb | input | 1 | Master read strobe from the upstream mailbox |
| m_rd_data | output | 8 | Upstream byte while `m_rd_stb` is high, else 0x00 |
| s_wr_stb | input | 1 | Slave write strobe into the upstream mailbox |
| s_wr_data | input | 8 | Slave write byte |
| s_rd_stb | input | 1 | Slave read strobe from the downstream mailbox |
| s_rd_data | output | 8 | Downstream byte while `s_rd_stb` is high, else 0x00 |
| m_dn_room_n | output | 1 | Low when the master may write downstream |
| s_dn_avail_n | output | 1 | Low when a downstream byte waits for the slave |
| s_up_room_n | output | 1 | Low when the slave may write upstream |
| m_up_avail_n | output | 1 | Low when an upstream byte waits for the master |
| m_overrun | output | 1 | Sticky: master wrote to a full downstream mailbox |
| m_underrun | output | 1 | Sticky: master read an empty upstream mailbox |
| s_overrun | output | 1 | Sticky: slave wrote to a full upstream mailbox |
| s_underrun | output | 1 | Sticky: slave read an empty downstream mailbox |
| err_clr | input | 1 | Clears all four sticky flags |

## Verification
The hardest cases to reach from the ports are those where both sides hit the same mailbox in one cycle:
- a read and a write to a full mailbox (R8);
- a read and a write to an empty mailbox (R9);
- an error event that lands in the same cycle as `err_clr` (R10).

Directed sequences first load a mailbox so that it is full or empty as required, then pulse both strobes together, then add the clear on top. A long run of random strobes on both sides follows. It hits these coincidences many times, and a behavioural model compares every flag and read-data port against the design on every clock.

// File: rtl/mbox_pkg.sv
// Package: shared types and constants for the mailbox link.
// Assumes: a single clock domain for both sides of the link.
package mbox_pkg;

    // Default byte width of one mailbox.
    localparam int unsigned MBOX_DATA_W = 8;

    // Number of directions carried by the link.
    localparam int unsigned MBOX_DIRS = 2;

    // Direction indices used by the generate loop in the top.
    localparam int unsigned DIR_DN = 0;
    localparam int unsigned DIR_UP = 1;

    // Protocol-violation events produced by one mailbox in one cycle.
    typedef struct packed {
        logic wr_refused;   // write strobe seen while full
        logic rd_empty;     // read strobe seen while empty
    } slot_evt_t;

endpackage

// File: rtl/mbox_slot.sv
// Module: one single-byte mailbox with a writer side and a reader side.
// What it does: latches a byte on an accepted write. Marks itself full until
// a read takes the byte. Exposes active-low room and available flags, and
// reports refused writes and empty reads as single-cycle events.
// Assumes: strobes are single-cycle pulses, synchronous to clk. When a read
// and a write reach a full slot together, the read wins and the write is
// refused.
module mbox_slot
    import mbox_pkg::*;
#(
    parameter int unsigned DATA_W = MBOX_DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_stb,
    output logic [DATA_W-1:0] rd_data,
    output logic              room_n,
    output logic              avail_n,
    output slot_evt_t         evt
);

    logic              full_q;
    logic [DATA_W-1:0] byte_q;
    logic              wr_take;
    logic              rd_take;

    // Accept decisions: a write is taken only into an empty slot, and a read empties only a full one.
    always_comb begin
        wr_take = wr_stb && !full_q;
        rd_take = rd_stb &&  full_q;
    end

    // Occupancy state: a read clears a full slot, and a write fills an empty one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full_q <= 1'b0;
        end else if (rd_take) begin
            full_q <= 1'b0;
        end else if (wr_take) begin
            full_q <= 1'b1;
        end
    end

    // Data latch: loaded only by an accepted write and kept through reads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            byte_q <= '0;
        end else if (wr_take) begin
            byte_q <= wr_data;
        end
    end

    // Outputs: handshake flags from the occupancy bit, read data gated by the strobe.
    always_comb begin
        room_n         = full_q;
        avail_n        = ~full_q;
        rd_data        = rd_stb ? byte_q : '0;
        evt.wr_refused = wr_stb &&  full_q;
        evt.rd_empty   = rd_stb && !full_q;
    end

    // R2
    wr_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && wr_stb && avail_n) |=> (!avail_n && room_n && byte_q == $past(wr_data)));

    // R3
    rd_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && rd_stb && !avail_n) |=> (avail_n && !room_n));

    // R6
    wr_refused_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && wr_stb && room_n) |=> $stable(byte_q));

    // R7
    rd_empty_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && rd_stb && !wr_stb && !room_n) |=> (!room_n && $stable(byte_q)));

    // R5
    rd_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_stb |-> (rd_data == '0));

endmodule

// File: rtl/mbox_sticky.sv
// Module: a bank of sticky error flags with a shared clear.
// What it does: each bit rises on its set pulse and holds until clr. A set in
// the same cycle as clr wins, so no event is lost.
// Assumes: set pulses are synchronous to clk.
module mbox_sticky #(
    parameter int unsigned N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic [N-1:0] set,
    output logic [N-1:0] flag
);

    for (genvar i = 0; i < N; i++) begin : g_bit
        logic flag_q;

        // Flag storage: set has priority over clear.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                flag_q <= 1'b0;
            end else if (set[i]) begin
                flag_q <= 1'b1;
            end else if (clr) begin
                flag_q <= 1'b0;
            end
        end

        assign flag[i] = flag_q;

        // R10
        sticky_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (rst_n && set[i]) |=> flag[i]);

        // R10
        sticky_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (rst_n && clr && !set[i]) |=> !flag[i]);

        // R10
        sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (rst_n && !clr && !set[i]) |=> $stable(flag[i]));
    end

endmodule

// File: rtl/mbox_link_top.sv
// Module: bidirectional single-byte mailbox link between a master and a slave.
// What it does: instantiates a downstream slot (master writes, slave reads)
// and an upstream slot (slave writes, master reads). Routes their protocol
// events into four sticky flags on the side that caused them.
// Assumes: one shared clock, synchronous active-low reset, single-cycle strobes.
module mbox_link_top
    import mbox_pkg::*;
#(
    parameter int unsigned DATA_W = MBOX_DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              m_wr_stb,
    input  logic [DATA_W-1:0] m_wr_data,
    input  logic              m_rd_stb,
    output logic [DATA_W-1:0] m_rd_data,
    input  logic              s_wr_stb,
    input  logic [DATA_W-1:0] s_wr_data,
    input  logic              s_rd_stb,
    output logic [DATA_W-1:0] s_rd_data,
    output logic              m_dn_room_n,
    output logic              s_dn_avail_n,
    output logic              s_up_room_n,
    output logic              m_up_avail_n,
    output logic              m_overrun,
    output logic              m_underrun,
    output logic              s_overrun,
    output logic              s_underrun,
    input  logic              err_clr
);

    localparam int unsigned N_STICKY = 2 * MBOX_DIRS;

    logic              wr_stb_a  [MBOX_DIRS];
    logic [DATA_W-1:0] wr_data_a [MBOX_DIRS];
    logic              rd_stb_a  [MBOX_DIRS];
    logic [DATA_W-1:0] rd_data_a [MBOX_DIRS];
    logic              room_a    [MBOX_DIRS];
    logic              avail_a   [MBOX_DIRS];
    slot_evt_t         evt_a     [MBOX_DIRS];
    logic [N_STICKY-1:0] err_set;
    logic [N_STICKY-1:0] err_flag;

    // Side mapping: the master writes downstream and reads upstream.
    always_comb begin
        wr_stb_a[DIR_DN]  = m_wr_stb;
        wr_data_a[DIR_DN] = m_wr_data;
        rd_stb_a[DIR_DN]  = s_rd_stb;
        wr_stb_a[DIR_UP]  = s_wr_stb;
        wr_data_a[DIR_UP] = s_wr_data;
        rd_stb_a[DIR_UP]  = m_rd_stb;
    end

    for (genvar d = 0; d < MBOX_DIRS; d++) begin : g_dir
        mbox_slot #(.DATA_W(DATA_W)) slot_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_stb  (wr_stb_a[d]),
            .wr_data (wr_data_a[d]),
            .rd_stb  (rd_stb_a[d]),
            .rd_data (rd_data_a[d]),
            .room_n  (room_a[d]),
            .avail_n (avail_a[d]),
            .evt     (evt_a[d])
        );
    end

    // Error routing: bit 0 master overrun, 1 slave underrun, 2 slave overrun, 3 master underrun.
    always_comb begin
        err_set[0] = evt_a[DIR_DN].wr_refused;
        err_set[1] = evt_a[DIR_DN].rd_empty;
        err_set[2] = evt_a[DIR_UP].wr_refused;
        err_set[3] = evt_a[DIR_UP].rd_empty;
    end

    mbox_sticky #(.N(N_STICKY)) sticky_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (err_clr),
        .set   (err_set),
        .flag  (err_flag)
    );

    // Port drive: flags and read data from the two slots, sticky bits to their sides.
    always_comb begin
        s_rd_data    = rd_data_a[DIR_DN];
        m_rd_data    = rd_data_a[DIR_UP];
        m_dn_room_n  = room_a[DIR_DN];
        s_dn_avail_n = avail_a[DIR_DN];
        s_up_room_n  = room_a[DIR_UP];
        m_up_avail_n = avail_a[DIR_UP];
        m_overrun    = err_flag[0];
        s_underrun   = err_flag[1];
        s_overrun    = err_flag[2];
        m_underrun   = err_flag[3];
    end

    // R8
    same_cycle_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && m_wr_stb && s_rd_stb && !s_dn_avail_n) |=> (!m_dn_room_n && m_overrun));

    // R9
    same_cycle_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && s_wr_stb && m_rd_stb && m_up_avail_n) |=> (!m_up_avail_n && m_underrun));

    // R6
    up_overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && s_wr_stb && s_up_room_n) |=> s_overrun);

    // R7
    dn_underrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && s_rd_stb && s_dn_avail_n) |=> s_underrun);

endmodule

// File: tb/mbox_link_top_tb_top.sv
`timescale 1ns/1ps
module mbox_link_top_tb_top;

    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          m_wr_stb, m_rd_stb, s_wr_stb, s_rd_stb, err_clr;
    logic [DW-1:0] m_wr_data, s_wr_data;
    logic [DW-1:0] m_rd_data, s_rd_data;
    logic          m_dn_room_n, s_dn_avail_n, s_up_room_n, m_up_avail_n;
    logic          m_overrun, m_underrun, s_overrun, s_underrun;

    always #2.5 clk = ~clk;

    mbox_link_top #(.DATA_W(DW)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .m_wr_stb(m_wr_stb), .m_wr_data(m_wr_data),
        .m_rd_stb(m_rd_stb), .m_rd_data(m_rd_data),
        .s_wr_stb(s_wr_stb), .s_wr_data(s_wr_data),
        .s_rd_stb(s_rd_stb), .s_rd_data(s_rd_data),
        .m_dn_room_n(m_dn_room_n), .s_dn_avail_n(s_dn_avail_n),
        .s_up_room_n(s_up_room_n), .m_up_avail_n(m_up_avail_n),
        .m_overrun(m_overrun), .m_underrun(m_underrun),
        .s_overrun(s_overrun), .s_underrun(s_underrun),
        .err_clr(err_clr)
    );

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    // Behavioural reference state.
    int dn_full, dn_val, up_full, up_val;
    int e_movr, e_mudr, e_sovr, e_sudr;

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_state(input string ctx);
        chk({ctx, " R2 R3 m_dn_room_n"},  m_dn_room_n,  dn_full);
        chk({ctx, " R2 R3 s_dn_avail_n"}, s_dn_avail_n, 1 - dn_full);
        chk({ctx, " R4 s_up_room_n"},     s_up_room_n,  up_full);
        chk({ctx, " R4 m_up_avail_n"},    m_up_avail_n, 1 - up_full);
        chk({ctx, " R6 R10 m_overrun"},   m_overrun,    e_movr);
        chk({ctx, " R7 R10 m_underrun"},  m_underrun,   e_mudr);
        chk({ctx, " R6 R10 s_overrun"},   s_overrun,    e_sovr);
        chk({ctx, " R7 R10 s_underrun"},  s_underrun,   e_sudr);
    endtask

    // One clock: drive at negedge, check read data combinationally, advance model, check flags after edge.
    task automatic cycle(input string ctx, input bit mw, input int mwd, input bit mr,
                         input bit sw, input int swd, input bit sr, input bit clr);
        int n_dn_full, n_up_full;
        @(negedge clk);
        m_wr_stb = mw; m_wr_data = mwd[DW-1:0]; m_rd_stb = mr;
        s_wr_stb = sw; s_wr_data = swd[DW-1:0]; s_rd_stb = sr;
        err_clr = clr;
        #0.5;
        chk({ctx, " R5 m_rd_data"}, m_rd_data, mr ? up_val : 0);
        chk({ctx, " R5 s_rd_data"}, s_rd_data, sr ? dn_val : 0);
        // downstream: the read wins on a full mailbox (R8), the write fills an empty one (R9)
        if (dn_full != 0) n_dn_full = sr ? 0 : 1;
        else              n_dn_full = mw ? 1 : 0;
        if (mw && dn_full == 0) dn_val = mwd & 8'hFF;
        if (mw && dn_full != 0)      e_movr = 1;
        else if (clr)                e_movr = 0;
        if (sr && dn_full == 0)      e_sudr = 1;
        else if (clr)                e_sudr = 0;
        // upstream, the same rules mirrored
        if (up_full != 0) n_up_full = mr ? 0 : 1;
        else              n_up_full = sw ? 1 : 0;
        if (sw && up_full == 0) up_val = swd & 8'hFF;
        if (sw && up_full != 0)      e_sovr = 1;
        else if (clr)                e_sovr = 0;
        if (mr && up_full == 0)      e_mudr = 1;
        else if (clr)                e_mudr = 0;
        dn_full = n_dn_full;
        up_full = n_up_full;
        @(posedge clk);
        #0.5;
        check_state(ctx);
    endtask

    task automatic idle(input string ctx);
        cycle(ctx, 0, 0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        rst_n = 1'b0;
        m_wr_stb = 0; m_rd_stb = 0; s_wr_stb = 0; s_rd_stb = 0; err_clr = 0;
        m_wr_data = '0; s_wr_data = '0;
        dn_full = 0; dn_val = 0; up_full = 0; up_val = 0;
        e_movr = 0; e_mudr = 0; e_sovr = 0; e_sudr = 0;
        repeat (3) @(posedge clk);
        #0.5;
        check_state("R1 reset");
        chk("R1 R5 m_rd_data idle", m_rd_data, 0);
        chk("R1 R5 s_rd_data idle", s_rd_data, 0);
        @(negedge clk);
        rst_n = 1'b1;
        idle("R1 after reset");

        // R2, R3: downstream byte
        cycle("R2 master write", 1, 8'hA5, 0, 0, 0, 0, 0);
        idle("R2 hold full");
        cycle("R3 slave read", 0, 0, 0, 0, 0, 1, 0);
        // R4: upstream byte
        cycle("R4 slave write", 0, 0, 0, 1, 8'h3C, 0, 0);
        cycle("R4 master read", 0, 0, 1, 0, 0, 0, 0);
        // R6: write into full downstream mailbox
        cycle("R6 fill", 1, 8'h11, 0, 0, 0, 0, 0);
        cycle("R6 refused write", 1, 8'h22, 0, 0, 0, 0, 0);
        cycle("R6 read keeps old", 0, 0, 0, 0, 0, 1, 0);
        // R7: read empty downstream mailbox returns last byte
        cycle("R7 empty read", 0, 0, 0, 0, 0, 1, 0);
        cycle("R10 clear", 0, 0, 0, 0, 0, 0, 1);
        // R8: same-cycle read and write on full mailbox
        cycle("R8 fill", 1, 8'h5A, 0, 0, 0, 0, 0);
        cycle("R8 both full", 1, 8'h77, 0, 0, 0, 1, 0);
        cycle("R8 empty after", 0, 0, 0, 0, 0, 1, 0);
        // R9: same-cycle read and write on empty upstream mailbox
        cycle("R9 both empty", 0, 0, 1, 1, 8'hC3, 0, 0);
        cycle("R9 read stored", 0, 0, 1, 0, 0, 0, 0);
        // R10: new event in clear cycle wins
        cycle("R10 clear with event", 0, 0, 1, 0, 0, 0, 1);
        cycle("R10 plain clear", 0, 0, 0, 0, 0, 0, 1);
        // R6 upstream overrun
        cycle("R6 up fill", 0, 0, 0, 1, 8'h01, 0, 0);
        cycle("R6 up refused", 0, 0, 0, 1, 8'h02, 0, 0);
        cycle("R6 up drain", 0, 0, 1, 0, 0, 0, 0);

        // Random traffic on both sides
        for (int i = 0; i < 4000; i++) begin
            cycle("R8 R9 R10 random",
                  1'($urandom_range(0, 1)), int'($urandom_range(0, 255)), 1'($urandom_range(0, 1)),
                  1'($urandom_range(0, 1)), int'($urandom_range(0, 255)), 1'($urandom_range(0, 1)),
                  ($urandom_range(0, 15) == 0));
        end
        idle("final");
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule